// File: doc/BRIEF.md
# Acquisition Run-State Controller

This block is the run-control state machine of an acquisition system. It keeps the run in one of four states: idle, ready, active and paused. It drives three enables toward the timing sequencer and the subsystems: start generation, CPU interrupts and a general subsystem enable. Software issues one-cycle commands on a small coded bus. The timing sequencer supplies two strobes: a DAQ-ready event, which marks the quiet gap before each cycle, and an end event, which follows the bunch train.

The run-affecting requests are activate, pause and resume. The controller does not apply them when they arrive. It records each one as a pending request and completes it on the next DAQ-ready event, so a run starts, halts or restarts only at a cycle boundary. The end, abort and error commands act at once. An end event that arrives in the active state while the status input reports a fault also acts at once. Setup is the only way back to ready. It starts a configuration phase that lasts until an external configuration-done handshake arrives.

Top module: `acq_run_ctrl`

## Requirements
- R1: After reset the state is idle (run_state code 0; ready=1, active=2, paused=3). All enables, both flags, cfg_busy and req_pending are low. While the state is idle, start_en, irq_en and subsys_en stay low.
- R2: A setup command (code 1) in idle, when no configuration is in progress, raises cfg_busy and clears err_flag in the next cycle. The cycle after cfg_done is seen high with cfg_busy set, the state is ready and cfg_busy is low.
- R3: An activate command (code 2) in ready raises irq_en and req_pending in the next cycle and leaves the state at ready. On the next DAQ-ready event the state becomes active, and start_en and subsys_en rise.
- R4: A pause command (code 3) in active is held pending. On the next DAQ-ready event the state becomes paused and start_en falls, while irq_en and subsys_en stay high.
- R5: A resume command (code 4) in paused is held pending. On the next DAQ-ready event the state becomes active and start_en rises again.
- R6: A DAQ-ready event in the same cycle as an activate, pause or resume command does not complete that request. Completion needs a later event.
- R7: An end command (code 5) in active or paused, or an abort command (code 6) in ready, active, paused or during configuration, returns the state to idle in the next cycle. All enables, req_pending and cfg_busy go low. This takes priority over a pending request completing in the same cycle.
- R8: An end event while active with status_err high sets err_flag and returns the state to idle with all enables low. While paused, end events have no effect.
- R9: An error command (code 7) is accepted in every state. It sets err_flag and returns the state to idle with all enables low.
- R10: Any command not listed as valid for the current state has no effect and sets illegal_flag, which stays set until reset. This includes code 0, a setup issued outside idle or during configuration, and a second request while one is pending.
- R11: Once set, err_flag stays high until a setup command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 3 | Command code (1 setup, 2 activate, 3 pause, 4 resume, 5 end, 6 abort, 7 error) |
| cfg_done | input | 1 | Configuration-complete handshake |
| daq_rdy_evt | input | 1 | DAQ-ready timing event strobe |
| end_evt | input | 1 | End-of-cycle timing event strobe |
| status_err | input | 1 | Status fault, sampled on end events |
| run_state | output | 2 | Current state code |
| cfg_busy | output | 1 | Configuration phase in progress |
| req_pending | output | 1 | A request waits for the next DAQ-ready event |
| start_en | output | 1 | Start generation enable |
| irq_en | output | 1 | CPU interrupt enable |
| subsys_en | output | 1 | Subsystem enable |
| err_flag | output | 1 | Run error flag |
| illegal_flag | output | 1 | Sticky illegal-command flag |

## Verification
Two collisions can happen in one cycle. The first is a request command arriving together with a DAQ-ready event. The bench drives both strobes on the same edge and checks that the state has not moved, while irq_en and req_pending show the request is recorded. A second event alone then completes the request. The second collision is a stop command arriving together with the event that would complete a pending resume. The bench checks that the machine lands in idle with every enable low and nothing left pending.

// File: rtl/acq_run_pkg.sv
package acq_run_pkg;

    localparam int CMD_W   = 3;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 2'd0,
        ST_READY  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_PAUSED = 2'd3
    } run_state_e;

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE     = 3'd0,
        CMD_SETUP    = 3'd1,
        CMD_ACTIVATE = 3'd2,
        CMD_PAUSE    = 3'd3,
        CMD_RESUME   = 3'd4,
        CMD_END      = 3'd5,
        CMD_ABORT    = 3'd6,
        CMD_ERROR    = 3'd7
    } cmd_e;

    typedef struct packed {
        run_state_e state;
        logic       busy;
        logic       pend;
        logic       start;
        logic       irq;
        logic       subsys;
        logic       err;
        logic       illegal;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{
        state:   ST_IDLE,
        busy:    1'b0,
        pend:    1'b0,
        start:   1'b0,
        irq:     1'b0,
        subsys:  1'b0,
        err:     1'b0,
        illegal: 1'b0
    };

endpackage

// File: rtl/acq_cmd_check.sv
module acq_cmd_check
    import acq_run_pkg::*;
(
    input  run_state_e state_q,
    input  logic       busy_q,
    input  logic       pend_q,
    input  logic       cmd_valid,
    input  cmd_e       cmd,
    output logic       accept,
    output logic       illegal
);

    logic legal;

    always_comb begin
        legal = 1'b0;
        if (cmd == CMD_ERROR) begin
            legal = 1'b1;
        end else if (busy_q) begin
            legal = (cmd == CMD_ABORT);
        end else begin
            unique case (state_q)
                ST_IDLE:   legal = (cmd == CMD_SETUP);
                ST_READY:  legal = (cmd == CMD_ABORT) ||
                                   (cmd == CMD_ACTIVATE && !pend_q);
                ST_ACTIVE: legal = (cmd == CMD_END) || (cmd == CMD_ABORT) ||
                                   (cmd == CMD_PAUSE && !pend_q);
                ST_PAUSED: legal = (cmd == CMD_END) || (cmd == CMD_ABORT) ||
                                   (cmd == CMD_RESUME && !pend_q);
                default:   legal = 1'b0;
            endcase
        end
        accept  = cmd_valid && legal;
        illegal = cmd_valid && !legal;
    end

endmodule

// File: rtl/acq_evt_qual.sv
module acq_evt_qual
    import acq_run_pkg::*;
(
    input  run_state_e state_q,
    input  logic       pend_q,
    input  logic       daq_rdy_evt,
    input  logic       end_evt,
    input  logic       status_err,
    output logic       fire_pend,
    output logic       fault_end
);

    always_comb begin
        fire_pend = daq_rdy_evt && pend_q;
        fault_end = end_evt && status_err && (state_q == ST_ACTIVE);
    end

endmodule

// File: rtl/acq_run_ctrl.sv
module acq_run_ctrl
    import acq_run_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [CMD_W-1:0]   cmd_code,
    input  logic               cfg_done,
    input  logic               daq_rdy_evt,
    input  logic               end_evt,
    input  logic               status_err,
    output logic [STATE_W-1:0] run_state,
    output logic               cfg_busy,
    output logic               req_pending,
    output logic               start_en,
    output logic               irq_en,
    output logic               subsys_en,
    output logic               err_flag,
    output logic               illegal_flag
);

    ctrl_t ctl_d, ctl_q;
    cmd_e  cmd;
    logic  accept, illegal;
    logic  fire_pend, fault_end;

    assign cmd = cmd_e'(cmd_code);

    acq_cmd_check u_check (
        .state_q   (ctl_q.state),
        .busy_q    (ctl_q.busy),
        .pend_q    (ctl_q.pend),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .accept    (accept),
        .illegal   (illegal)
    );

    acq_evt_qual u_qual (
        .state_q     (ctl_q.state),
        .pend_q      (ctl_q.pend),
        .daq_rdy_evt (daq_rdy_evt),
        .end_evt     (end_evt),
        .status_err  (status_err),
        .fire_pend   (fire_pend),
        .fault_end   (fault_end)
    );

    always_comb begin
        ctl_d = ctl_q;

        // pending request completes on the DAQ-ready event
        if (fire_pend) begin
            ctl_d.pend = 1'b0;
            unique case (ctl_q.state)
                ST_READY: begin
                    ctl_d.state  = ST_ACTIVE;
                    ctl_d.start  = 1'b1;
                    ctl_d.subsys = 1'b1;
                end
                ST_ACTIVE: begin
                    ctl_d.state = ST_PAUSED;
                    ctl_d.start = 1'b0;
                end
                ST_PAUSED: begin
                    ctl_d.state = ST_ACTIVE;
                    ctl_d.start = 1'b1;
                end
                default: ;
            endcase
        end

        // configuration handshake
        if (ctl_q.busy && cfg_done) begin
            ctl_d.busy  = 1'b0;
            ctl_d.state = ST_READY;
        end

        // accepted commands (immediate ones override the event path)
        if (accept) begin
            unique case (cmd)
                CMD_SETUP: begin
                    ctl_d.busy = 1'b1;
                    ctl_d.err  = 1'b0;
                end
                CMD_ACTIVATE: begin
                    ctl_d.pend = 1'b1;
                    ctl_d.irq  = 1'b1;
                end
                CMD_PAUSE, CMD_RESUME: ctl_d.pend = 1'b1;
                CMD_END, CMD_ABORT, CMD_ERROR: begin
                    ctl_d.state  = ST_IDLE;
                    ctl_d.busy   = 1'b0;
                    ctl_d.pend   = 1'b0;
                    ctl_d.start  = 1'b0;
                    ctl_d.irq    = 1'b0;
                    ctl_d.subsys = 1'b0;
                    if (cmd == CMD_ERROR) ctl_d.err = 1'b1;
                end
                default: ;
            endcase
        end

        // faulty end-of-cycle status ends the run
        if (fault_end) begin
            ctl_d.state  = ST_IDLE;
            ctl_d.pend   = 1'b0;
            ctl_d.start  = 1'b0;
            ctl_d.irq    = 1'b0;
            ctl_d.subsys = 1'b0;
            ctl_d.err    = 1'b1;
        end

        if (illegal) ctl_d.illegal = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTRL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign run_state    = ctl_q.state;
    assign cfg_busy     = ctl_q.busy;
    assign req_pending  = ctl_q.pend;
    assign start_en     = ctl_q.start;
    assign irq_en       = ctl_q.irq;
    assign subsys_en    = ctl_q.subsys;
    assign err_flag     = ctl_q.err;
    assign illegal_flag = ctl_q.illegal;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == ST_IDLE) |-> (!start_en && !irq_en && !subsys_en));

    p_activate_on_evt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == ST_ACTIVE && $past(run_state) == ST_READY) |-> $past(daq_rdy_evt));

    p_pause_on_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == ST_PAUSED && $past(run_state) == ST_ACTIVE) |-> $past(daq_rdy_evt));

    p_resume_on_evt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == ST_ACTIVE && $past(run_state) == ST_PAUSED) |-> $past(daq_rdy_evt));

    p_stop_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_code == CMD_END || cmd_code == CMD_ABORT) &&
         (run_state == ST_ACTIVE || run_state == ST_PAUSED))
        |=> (run_state == ST_IDLE && !start_en && !req_pending));

    p_paused_end_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == ST_PAUSED && !cmd_valid) |=> (run_state != ST_IDLE));

    p_illegal_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_flag |=> illegal_flag);

    p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flag) |-> $past(cmd_valid && cmd_code == CMD_SETUP));

endmodule

// File: tb/acq_run_ctrl_bench.sv
module acq_run_ctrl_bench;

    localparam logic [2:0] C_NONE = 3'd0, C_SETUP = 3'd1, C_ACT = 3'd2,
        C_PAUSE = 3'd3, C_RESUME = 3'd4, C_END = 3'd5, C_ABORT = 3'd6, C_ERR = 3'd7;
    localparam logic [1:0] S_IDLE = 2'd0, S_READY = 2'd1, S_ACTIVE = 2'd2, S_PAUSED = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic       cfg_done = 1'b0;
    logic       daq_rdy_evt = 1'b0;
    logic       end_evt = 1'b0;
    logic       status_err = 1'b0;
    logic [1:0] run_state;
    logic cfg_busy, req_pending, start_en, irq_en, subsys_en, err_flag, illegal_flag;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    acq_run_ctrl u_acq_run_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cfg_done(cfg_done), .daq_rdy_evt(daq_rdy_evt), .end_evt(end_evt),
        .status_err(status_err), .run_state(run_state), .cfg_busy(cfg_busy),
        .req_pending(req_pending), .start_en(start_en), .irq_en(irq_en),
        .subsys_en(subsys_en), .err_flag(err_flag), .illegal_flag(illegal_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // outputs packed as {start, irq, subsys}
    function automatic int ens();
        return {29'd0, start_en, irq_en, subsys_en};
    endfunction

    task automatic cmd(input logic [2:0] c);
        cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = C_NONE;
    endtask

    task automatic daq();
        daq_rdy_evt = 1'b1;
        @(negedge clk);
        daq_rdy_evt = 1'b0;
    endtask

    task automatic endev(input logic e);
        end_evt = 1'b1; status_err = e;
        @(negedge clk);
        end_evt = 1'b0; status_err = 1'b0;
    endtask

    task automatic done();
        cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
    endtask

    task automatic to_active();
        cmd(C_SETUP); done(); cmd(C_ACT); daq();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "state", run_state, S_IDLE);
        chk("R1", "enables", ens(), 0);
        chk("R1", "flags", {err_flag, illegal_flag, cfg_busy, req_pending}, 0);
    endtask

    task automatic t_setup();
        cmd(C_SETUP);
        chk("R2", "busy", cfg_busy, 1);
        @(negedge clk);
        chk("R2", "still idle", run_state, S_IDLE);
        chk("R1", "idle enables", ens(), 0);
        done();
        chk("R2", "ready", run_state, S_READY);
        chk("R2", "busy cleared", cfg_busy, 0);
    endtask

    task automatic t_activate_collide();
        cmd_valid = 1'b1; cmd_code = C_ACT; daq_rdy_evt = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = C_NONE; daq_rdy_evt = 1'b0;
        chk("R6", "state held", run_state, S_READY);
        chk("R3", "irq early", irq_en, 1);
        chk("R3", "pending", req_pending, 1);
        chk("R3", "no start yet", start_en, 0);
        daq();
        chk("R3", "active", run_state, S_ACTIVE);
        chk("R3", "enables", ens(), 7);
        chk("R3", "pending cleared", req_pending, 0);
    endtask

    task automatic t_pause_resume();
        cmd(C_PAUSE);
        chk("R4", "wait for event", run_state, S_ACTIVE);
        chk("R4", "start kept", start_en, 1);
        daq();
        chk("R4", "paused", run_state, S_PAUSED);
        chk("R4", "enables", ens(), 3);
        endev(1'b1);
        chk("R8", "paused end ignored", run_state, S_PAUSED);
        chk("R8", "no err", err_flag, 0);
        cmd(C_RESUME);
        chk("R5", "wait for event", run_state, S_PAUSED);
        daq();
        chk("R5", "active", run_state, S_ACTIVE);
        chk("R5", "start back", start_en, 1);
    endtask

    task automatic t_stop_priority();
        cmd(C_PAUSE); daq();
        cmd(C_RESUME);
        cmd_valid = 1'b1; cmd_code = C_END; daq_rdy_evt = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = C_NONE; daq_rdy_evt = 1'b0;
        chk("R7", "idle", run_state, S_IDLE);
        chk("R7", "enables", ens(), 0);
        chk("R7", "pending dropped", req_pending, 0);
    endtask

    task automatic t_fault();
        to_active();
        endev(1'b0);
        chk("R8", "clean end", run_state, S_ACTIVE);
        endev(1'b1);
        chk("R8", "fault idle", run_state, S_IDLE);
        chk("R8", "err set", err_flag, 1);
        chk("R8", "enables", ens(), 0);
        repeat (4) @(negedge clk);
        chk("R11", "err holds", err_flag, 1);
        cmd(C_SETUP);
        chk("R11", "err cleared", err_flag, 0);
        cmd(C_ABORT);
        chk("R7", "abort config", {run_state, cfg_busy}, 0);
        cmd(C_SETUP); done(); cmd(C_ACT);
        cmd(C_ABORT);
        chk("R7", "abort ready", run_state, S_IDLE);
        chk("R7", "irq off", irq_en, 0);
    endtask

    task automatic t_error_cmd();
        to_active();
        cmd(C_ERR);
        chk("R9", "idle", run_state, S_IDLE);
        chk("R9", "err set", err_flag, 1);
        chk("R9", "enables", ens(), 0);
    endtask

    task automatic t_illegal();
        chk("R10", "clean before", illegal_flag, 0);
        cmd(C_PAUSE);
        chk("R10", "flag", illegal_flag, 1);
        chk("R10", "state kept", run_state, S_IDLE);
        chk("R10", "err kept", err_flag, 1);
        cmd(C_SETUP); done();
        cmd(C_RESUME);
        chk("R10", "resume ignored", {run_state, irq_en, req_pending}, {S_READY, 2'b00});
        cmd(C_ACT); cmd(C_ACT); daq();
        chk("R10", "dup ignored", run_state, S_ACTIVE);
        cmd(C_NONE);
        chk("R10", "code0 ignored", {run_state, req_pending}, {S_ACTIVE, 1'b0});
        repeat (3) @(negedge clk);
        chk("R10", "sticky", illegal_flag, 1);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_setup();
        t_activate_collide();
        t_pause_resume();
        t_stop_priority();
        t_fault();
        t_error_cmd();
        t_illegal();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule